// File: doc/BRIEF.md
# Symmetry-Folded Transform Coefficient Decoder

This block supplies one processing element of a systolic transform array with the kernel coefficient it has to multiply by. It receives the element's row and column coordinates, the transform order as a base-two exponent, a kernel type code and a pass selector that tells row-wise from column-wise processing. From these it forms the cosine angle index of the coefficient, folds that index into the first quadrant, and looks up the coefficient magnitude as a 10-bit multiplier control word. The sign is produced on a separate output.

Each kernel is stored only as its first column: N magnitudes indexed by angle step k, in units of pi/(2N). Every other entry of an order-N kernel is rebuilt from that column by quadrant folding and sign logic, so each ROM segment needs no more than the largest order's worth of words. A folded offset of exactly N stands for cos(pi/2) and gives a zero word without a ROM read. Both outputs are registered under a clock enable, so they line up with the element's MAC stage.

Top module: `kc_coef_decoder`

## Requirements
- R1: While rst_n is low, mult_ctrl and coef_neg are 0 at once, with no clock edge needed. Release passes through a two-stage synchronizer, so the first load after release happens on the third rising edge.
- R2: When en is high at a rising edge, both outputs load the value decoded from the inputs present at that edge. When en is low, both outputs hold.
- R3: In the row pass (col_pass = 0) the angle index is f = (2*col + 1) * row, with row and col taken as full 4-bit unsigned values. The order is N = 2^log2n, with log2n from 1 to 4. Only f mod 4N affects the result.
- R4: In the column pass (col_pass = 1) the coordinate roles swap: f = (2*row + 1) * col.
- R5: The quadrant is q = floor((f mod 4N) / N) and the low part is m = f mod N. The folded offset is m when q is 0 or 2, and N - m when q is 1 or 3.
- R6: coef_neg is 1 exactly when q is 1 or 2. This holds for every type code and also when the word is zero.
- R7: mult_ctrl is entry [offset] of the ROM segment chosen by the type code, at address {type, offset[3:0]}. Segment contents by type, with entries k = 0 upward: 0 = {1,1}; 1 = {1,1,1,1}; 2 = {1,2,1,1}; 3 = {2,3,2,1}; 4 = {17,22,17,10}; 5 = {64,83,64,36}; 6 = {8,12,8,10,8,6,4,3}; 7 = {8,10,10,9,8,6,4,2}; 8 = {12,16,16,15,12,9,6,4}; 9 = {64,89,83,75,64,50,36,18}; 10 = {64,90,89,87,83,80,75,70,64,57,50,43,36,25,18,9}. Entries past a segment's listed length read 0.
- R8: A folded offset equal to N gives mult_ctrl = 0 without a ROM read.
- R9: Type codes 11 to 15 select no segment and give mult_ctrl = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the output registers |
| col_pass | input | 1 | 0 = row-wise pass, 1 = column-wise pass |
| log2n | input | 3 | Transform order exponent, N = 2^log2n, legal 1 to 4 |
| ktype | input | 4 | Kernel type code selecting a ROM segment |
| row | input | 4 | Element vertical coordinate |
| col | input | 4 | Element horizontal coordinate |
| mult_ctrl | output | 10 | Registered multiplier control word (coefficient magnitude) |
| coef_neg | output | 1 | Registered coefficient sign, 1 = negative |

## Verification
The checker assumes that log2n stays between 1 and 4 whenever en is high, so that the quadrant and offset masks are meaningful, and that every input is known and held steady around each rising edge. It does not assume that the coordinates are below N: the wrap of f above 4N and the zero-offset case are reachable only with out-of-range coordinates, and these are legal stimulus. The bench changes inputs only on falling edges and uses only exponents from 1 to 4. It pairs type codes with their own orders, except in the vectors aimed at the zero bypass and at unused type codes.

// File: rtl/kc_pkg.sv
package kc_pkg;

  localparam int KC_NUM_KERNELS = 11;
  localparam int KC_CW          = 10;

  typedef logic [1:0] quad_t;

  // Order of each stored kernel (number of first-column entries).
  function automatic int kern_order(input int t);
    int ord;
    case (t)
      0:             ord = 2;
      1, 2, 3, 4, 5: ord = 4;
      6, 7, 8, 9:    ord = 8;
      10:            ord = 16;
      default:       ord = 0;
    endcase
    return ord;
  endfunction

  // First-column magnitude of kernel t at angle step k.
  // The entry at k = order/2 always equals the entry at k = 0 (cos(pi/4)
  // row of a dyadic-symmetric kernel), so it is not written out twice.
  function automatic int kern_mag(input int t, input int k);
    int ord;
    int kk;
    int v;
    ord = kern_order(t);
    v   = 0;
    if (k < ord) begin
      kk = (k == ord / 2) ? 0 : k;
      case (t)
        0, 1: v = 1;
        2: case (kk) 0: v = 1;  1: v = 2;  3: v = 1;  default: v = 0; endcase
        3: case (kk) 0: v = 2;  1: v = 3;  3: v = 1;  default: v = 0; endcase
        4: case (kk) 0: v = 17; 1: v = 22; 3: v = 10; default: v = 0; endcase
        5: case (kk) 0: v = 64; 1: v = 83; 3: v = 36; default: v = 0; endcase
        6: case (kk)
             0: v = 8;  1: v = 12; 2: v = 8;  3: v = 10;
             5: v = 6;  6: v = 4;  7: v = 3;  default: v = 0;
           endcase
        7: case (kk)
             0: v = 8;  1: v = 10; 2: v = 10; 3: v = 9;
             5: v = 6;  6: v = 4;  7: v = 2;  default: v = 0;
           endcase
        8: case (kk)
             0: v = 12; 1: v = 16; 2: v = 16; 3: v = 15;
             5: v = 9;  6: v = 6;  7: v = 4;  default: v = 0;
           endcase
        9: case (kk)
             0: v = 64; 1: v = 89; 2: v = 83; 3: v = 75;
             5: v = 50; 6: v = 36; 7: v = 18; default: v = 0;
           endcase
        10: case (kk)
             0:  v = 64; 1:  v = 90; 2:  v = 89; 3:  v = 87;
             4:  v = 83; 5:  v = 80; 6:  v = 75; 7:  v = 70;
             9:  v = 57; 10: v = 50; 11: v = 43; 12: v = 36;
             13: v = 25; 14: v = 18; 15: v = 9;  default: v = 0;
           endcase
        default: v = 0;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/kc_rst_sync.sv
module kc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/kc_angle.sv
module kc_angle #(
  parameter  int COORD_W = 4,
  parameter  int LOG2N_W = 3,
  localparam int F_W     = 2 * COORD_W + 1
) (
  input  logic               col_pass_i,
  input  logic [LOG2N_W-1:0] log2n_i,
  input  logic [COORD_W-1:0] row_i,
  input  logic [COORD_W-1:0] col_i,
  output kc_pkg::quad_t      quad_o,
  output logic [COORD_W-1:0] low_o
);

  logic [COORD_W-1:0] odd_src;
  logic [COORD_W-1:0] scale_src;
  logic [F_W-1:0]     angle;
  logic [F_W-1:0]     keep_mask;
  logic [F_W-1:0]     low_mask;
  logic [F_W-1:0]     kept;

  always_comb begin
    // Row pass: (2c+1)*r. Column pass: (2r+1)*c.
    odd_src   = col_pass_i ? row_i : col_i;
    scale_src = col_pass_i ? col_i : row_i;
    angle     = F_W'({odd_src, 1'b1}) * F_W'(scale_src);
    // Whole turns of 2*pi sit above bit log2n+1 and are dropped.
    keep_mask = (F_W'(1) << (int'(log2n_i) + 2)) - F_W'(1);
    low_mask  = (F_W'(1) << int'(log2n_i)) - F_W'(1);
    kept      = angle & keep_mask;
    quad_o    = 2'(kept >> log2n_i);
    low_o     = COORD_W'(kept & low_mask);
  end

endmodule

// File: rtl/kc_fold.sv
module kc_fold #(
  parameter int COORD_W = 4,
  parameter int LOG2N_W = 3
) (
  input  kc_pkg::quad_t      quad_i,
  input  logic [COORD_W-1:0] low_i,
  input  logic [LOG2N_W-1:0] log2n_i,
  output logic [COORD_W-1:0] idx_o,
  output logic               zero_o,
  output logic               neg_o
);

  logic [COORD_W:0] n_val;
  logic [COORD_W:0] low_ext;
  logic [COORD_W:0] folded;

  always_comb begin
    n_val   = (COORD_W + 1)'(1) << log2n_i;
    low_ext = {1'b0, low_i};
    // Odd quadrants mirror about pi/2 (or 3*pi/2).
    folded  = quad_i[0] ? (n_val - low_ext) : low_ext;
    zero_o  = (folded == n_val);
    idx_o   = COORD_W'(folded);
    // Cosine is negative in the second and third quadrants.
    neg_o   = quad_i[1] ^ quad_i[0];
  end

endmodule

// File: rtl/kc_seg_rom.sv
module kc_seg_rom #(
  parameter  int NUM_KERNELS = 11,
  parameter  int IDX_W       = 4,
  parameter  int TYPE_W      = 4,
  parameter  int CW          = 10,
  localparam int ADDR_W      = TYPE_W + IDX_W
) (
  input  logic [TYPE_W-1:0] type_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [CW-1:0]     word_o
);

  logic [ADDR_W-1:0]                  addr;
  logic [TYPE_W-1:0]                  seg_sel;
  logic [IDX_W-1:0]                   seg_off;
  logic [NUM_KERNELS-1:0][CW-1:0]     seg_word;

  assign addr    = {type_i, idx_i};
  assign seg_sel = addr[ADDR_W-1:IDX_W];
  assign seg_off = addr[IDX_W-1:0];

  // One constant segment per kernel, each indexed by the folded offset.
  for (genvar s = 0; s < NUM_KERNELS; s++) begin : g_seg
    assign seg_word[s] = CW'(kc_pkg::kern_mag(s, int'(seg_off)));
  end

  always_comb begin
    word_o = '0;
    for (int s = 0; s < NUM_KERNELS; s++) begin
      if (int'(seg_sel) == s) word_o = seg_word[s];
    end
  end

endmodule

// File: rtl/kc_coef_decoder.sv
module kc_coef_decoder #(
  parameter  int MAX_LOG2N   = 4,
  parameter  int NUM_KERNELS = kc_pkg::KC_NUM_KERNELS,
  parameter  int CW          = kc_pkg::KC_CW,
  localparam int COORD_W     = MAX_LOG2N,
  localparam int LOG2N_W     = $clog2(MAX_LOG2N + 1),
  localparam int TYPE_W      = $clog2(NUM_KERNELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               col_pass,
  input  logic [LOG2N_W-1:0] log2n,
  input  logic [TYPE_W-1:0]  ktype,
  input  logic [COORD_W-1:0] row,
  input  logic [COORD_W-1:0] col,
  output logic [CW-1:0]      mult_ctrl,
  output logic               coef_neg
);

  logic               rst_sync_n;
  kc_pkg::quad_t      quad;
  logic [COORD_W-1:0] low_part;
  logic [COORD_W-1:0] fold_idx;
  logic               fold_zero;
  logic               fold_neg;
  logic [CW-1:0]      rom_word;
  logic [CW-1:0]      ctrl_d;
  logic               neg_d;
  logic [CW-1:0]      ctrl_q;
  logic               neg_q;

  kc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kc_angle #(
    .COORD_W (COORD_W),
    .LOG2N_W (LOG2N_W)
  ) u_angle (
    .col_pass_i (col_pass),
    .log2n_i    (log2n),
    .row_i      (row),
    .col_i      (col),
    .quad_o     (quad),
    .low_o      (low_part)
  );

  kc_fold #(
    .COORD_W (COORD_W),
    .LOG2N_W (LOG2N_W)
  ) u_fold (
    .quad_i  (quad),
    .low_i   (low_part),
    .log2n_i (log2n),
    .idx_o   (fold_idx),
    .zero_o  (fold_zero),
    .neg_o   (fold_neg)
  );

  kc_seg_rom #(
    .NUM_KERNELS (NUM_KERNELS),
    .IDX_W       (COORD_W),
    .TYPE_W      (TYPE_W),
    .CW          (CW)
  ) u_rom (
    .type_i (ktype),
    .idx_i  (fold_idx),
    .word_o (rom_word)
  );

  // Next-state: zero coefficient bypasses the ROM word.
  always_comb begin
    ctrl_d = fold_zero ? '0 : rom_word;
    neg_d  = fold_neg;
  end

  // Output registers with clock enable.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      neg_q  <= 1'b0;
    end else if (en) begin
      ctrl_q <= ctrl_d;
      neg_q  <= neg_d;
    end
  end

  assign mult_ctrl = ctrl_q;
  assign coef_neg  = neg_q;

endmodule

// File: rtl/kc_coef_decoder_chk.sv
module kc_coef_decoder_chk #(
  parameter int NUM_KERNELS = 11,
  parameter int LOG2N_W     = 3,
  parameter int TYPE_W      = 4,
  parameter int COORD_W     = 4,
  parameter int CW          = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               col_pass,
  input logic [LOG2N_W-1:0] log2n,
  input logic [TYPE_W-1:0]  ktype,
  input logic [COORD_W-1:0] row,
  input logic [COORD_W-1:0] col,
  input logic [CW-1:0]      mult_ctrl,
  input logic               coef_neg
);

  // R1: outputs are cleared when reset is seen released.
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (mult_ctrl == '0) && !coef_neg);

  // R2: without enable both outputs hold.
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(mult_ctrl) && $stable(coef_neg));

  // R3 (with R6): row pass with row 0 has angle 0, never negative.
  assert_row_zero_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && !col_pass && (row == '0) |=> !coef_neg);

  // R4 (with R6): column pass with col 0 has angle 0, never negative.
  assert_col_zero_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && col_pass && (col == '0) |=> !coef_neg);

  // R8: order 2, row 2, col 0 in row pass lands on pi/2: zero word, sign set.
  assert_zero_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en && !col_pass && (log2n == LOG2N_W'(1)) && (row == COORD_W'(2)) && (col == '0)
    |=> (mult_ctrl == '0) && coef_neg);

  // R9: unused type codes read zero.
  assert_bad_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en && (int'(ktype) >= NUM_KERNELS) |=> (mult_ctrl == '0));

endmodule

bind kc_coef_decoder kc_coef_decoder_chk #(
  .NUM_KERNELS (NUM_KERNELS),
  .LOG2N_W     (LOG2N_W),
  .TYPE_W      (TYPE_W),
  .COORD_W     (COORD_W),
  .CW          (CW)
) u_kc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .col_pass  (col_pass),
  .log2n     (log2n),
  .ktype     (ktype),
  .row       (row),
  .col       (col),
  .mult_ctrl (mult_ctrl),
  .coef_neg  (coef_neg)
);

// File: tb/tb_kc_coef_decoder.sv
module tb_kc_coef_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 25;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic       col_pass;
  logic [2:0] log2n;
  logic [3:0] ktype;
  logic [3:0] row;
  logic [3:0] col;
  logic [9:0] mult_ctrl;
  logic       coef_neg;

  int checks;
  int failures;
  bit done;

  kc_coef_decoder dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .col_pass  (col_pass),
    .log2n     (log2n),
    .ktype     (ktype),
    .row       (row),
    .col       (col),
    .mult_ctrl (mult_ctrl),
    .coef_neg  (coef_neg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // {col_pass, log2n, ktype, row, col, expected ctrl, expected sign}
  localparam logic [26:0] VECS [NVEC] = '{
    {1'b0, 3'd3, 4'd9,  4'd0,  4'd5,  10'd64, 1'b0}, // R3 R7: f=0
    {1'b0, 3'd3, 4'd9,  4'd1,  4'd0,  10'd89, 1'b0}, // R7: k=1
    {1'b0, 3'd3, 4'd9,  4'd1,  4'd3,  10'd18, 1'b0}, // R5: q0 offset 7
    {1'b0, 3'd3, 4'd9,  4'd1,  4'd4,  10'd18, 1'b1}, // R5 R6: q1 fold 9->7
    {1'b0, 3'd3, 4'd9,  4'd3,  4'd5,  10'd89, 1'b0}, // R3: f=33 wraps to 1
    {1'b0, 3'd3, 4'd9,  4'd2,  4'd3,  10'd83, 1'b1}, // R5 R6: q1 offset 2
    {1'b0, 3'd3, 4'd9,  4'd5,  4'd6,  10'd89, 1'b0}, // R3: f=65 wraps to 1
    {1'b0, 3'd3, 4'd9,  4'd6,  4'd2,  10'd83, 1'b0}, // R6: q3 positive
    {1'b0, 3'd3, 4'd9,  4'd7,  4'd1,  10'd50, 1'b1}, // R6: q2 negative
    {1'b1, 3'd3, 4'd6,  4'd1,  4'd2,  10'd4,  1'b0}, // R4: f=3*2=6
    {1'b1, 3'd3, 4'd6,  4'd0,  4'd3,  10'd10, 1'b0}, // R4: f=1*3=3
    {1'b1, 3'd2, 4'd2,  4'd2,  4'd1,  10'd1,  1'b1}, // R4 R5: f=5, q1
    {1'b0, 3'd2, 4'd5,  4'd3,  4'd2,  10'd83, 1'b0}, // R5: f=15, q3
    {1'b0, 3'd2, 4'd4,  4'd1,  4'd1,  10'd10, 1'b0}, // R7: segment 4
    {1'b0, 3'd1, 4'd0,  4'd1,  4'd1,  10'd1,  1'b1}, // R5 R6: order 2
    {1'b0, 3'd4, 4'd10, 4'd3,  4'd7,  10'd25, 1'b1}, // R5: order 16, q2
    {1'b0, 3'd4, 4'd10, 4'd1,  4'd0,  10'd90, 1'b0}, // R7: segment 10
    {1'b0, 3'd3, 4'd7,  4'd2,  4'd0,  10'd10, 1'b0}, // R7: segment 7
    {1'b0, 3'd3, 4'd8,  4'd1,  4'd2,  10'd9,  1'b0}, // R7: segment 8
    {1'b0, 3'd2, 4'd3,  4'd1,  4'd0,  10'd3,  1'b0}, // R7: segment 3
    {1'b0, 3'd1, 4'd0,  4'd2,  4'd0,  10'd0,  1'b1}, // R8: offset N=2
    {1'b0, 3'd2, 4'd2,  4'd4,  4'd0,  10'd0,  1'b1}, // R8: offset N=4
    {1'b0, 3'd3, 4'd12, 4'd1,  4'd0,  10'd0,  1'b0}, // R9: unused type
    {1'b0, 3'd2, 4'd5,  4'd15, 4'd15, 10'd83, 1'b0}, // R3: f=465 wraps
    {1'b0, 3'd4, 4'd10, 4'd5,  4'd9,  10'd90, 1'b1}  // R5: f=95, q1
  };

  task automatic check(input string tag, input logic [9:0] exp_ctrl,
                       input logic exp_neg);
    checks++;
    if (mult_ctrl !== exp_ctrl || coef_neg !== exp_neg) begin
      failures++;
      $display("FAIL %s: ctrl=%0d neg=%0b expected ctrl=%0d neg=%0b",
               tag, mult_ctrl, coef_neg, exp_ctrl, exp_neg);
    end
  endtask

  task automatic drive(input logic [26:0] v);
    col_pass = v[26];
    log2n    = v[25:23];
    ktype    = v[22:19];
    row      = v[18:15];
    col      = v[14:11];
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    en       = 1'b0;
    col_pass = 1'b0;
    log2n    = 3'd3;
    ktype    = 4'd9;
    row      = 4'd0;
    col      = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset state", 10'd0, 1'b0);

    // Vector table walk, en held high.
    en = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("vector %0d (R3/R4/R5/R6/R7/R8/R9)", i),
            VECS[i][10:1], VECS[i][0]);
    end

    // R2: enable low holds the last value (vector 24: 90, negative).
    en = 1'b0;
    drive(VECS[0]);
    repeat (2) @(negedge clk);
    check("R2 hold with en low", 10'd90, 1'b1);
    en = 1'b1;
    @(negedge clk);
    check("R2 load after en high", 10'd64, 1'b0);

    // R1: asynchronous clear mid-run, between edges.
    drive(VECS[3]);
    @(negedge clk);
    check("R1 pre-reset value", 10'd18, 1'b1);
    #(CLK_PERIOD / 4);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 10'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: two synchronizer edges keep the registers cleared.
    @(negedge clk);
    check("R1 sync release edge 1", 10'd0, 1'b0);
    @(negedge clk);
    check("R1 sync release edge 2", 10'd0, 1'b0);
    @(negedge clk);
    check("R1 first load after release", 10'd18, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule